// File: doc/BRIEF.md
# Vector Interface DMA Completion Sequencer

This block decides what a DMA channel feeding a vector-unit interface does next. It acts once on each trigger pulse. It looks at the remaining quadword count, the done flag, the pending interrupt count, the current tag size and command, the stall-status bits, the global DMA enable, the vector-unit wait flag and the chain-in-progress flag. From these it picks exactly one outcome: stall on an interrupt, hold for the vector unit, continue the chain, hold because DMA is masked, set up the next tag, or finish the channel. It also keeps a FIFO occupancy field, a sticky interrupt status bit and a command-status bit.

The interface interrupt pulse also serves as the request to decrement the pending interrupt count, which the surrounding logic owns. A finish produces three single-cycle strobes: clear the channel start bit, clear the stall and interrupt-offset flags, and raise the DMA-done interrupt. The parameter `LARGE_FIFO` chooses between the 16-deep channel and the 8-deep channel.

Top module: `vdc_top`

## Requirements
- R1: With `LARGE_FIFO=1`, each evaluation sets `fifo_cnt_o` to min(`qwc_i`, 16).
- R2: With `LARGE_FIFO=0`, each evaluation sets `fifo_cnt_o` to min(`qwc_i`, 8).
- R3: An evaluation fires `vif_irq_o` for one cycle only when `pend_cnt_i` is nonzero, `tag_size_i` is zero and `cmd_i` is zero. Firing sets `int_stat_o`, which then stays at 1 until reset.
- R4: If the interrupt fires, any bit of `stall_bits_i` is set, and either `qwc_i` is nonzero or `done_i` is 0, the outcome is STALL (code 3). No chain, setup or finish strobe is raised.
- R5: When R4 does not apply and `unit_wait_i` is 1, the outcome is WAIT (code 4). No strobe other than `vif_irq_o` is raised, and `cmd_wait_o` keeps its value.
- R6: When neither STALL nor WAIT applies, `cmd_wait_o` becomes 1 if `cmd_i`≠0, `done_i`=1 and `qwc_i`=0. It becomes 0 (idle) if `cmd_i`=0. Otherwise it holds.
- R7: Next in priority, `in_prog_i`=1 gives outcome CHAIN (code 1) and a one-cycle `chain_o` pulse. This happens whatever the values of `done_i` and `dma_en_i`.
- R8: Next, `done_i`=0 with `dma_en_i`=0 gives outcome MASK (code 5). No strobe is raised.
- R9: Next, `done_i`=0 with `dma_en_i`=1 gives outcome SETUP (code 2) and a one-cycle `setup_o` pulse.
- R10: Otherwise the outcome is FINISH (code 6). `str_clr_o`, `flags_clr_o` and `dma_irq_o` all pulse for one cycle.
- R11: Results appear on the clock edge after `eval_i` rises. A level of `eval_i` held high counts as one evaluation. Between evaluations every registered output holds and every strobe is 0.
- R12: After reset, `fifo_cnt_o`, `int_stat_o` and `cmd_wait_o` are 0, the outcome is NONE (code 0), and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluation trigger; acts on its rising edge |
| qwc_i | input | QWC_W | Remaining quadword count |
| done_i | input | 1 | Transfer done flag |
| pend_cnt_i | input | PEND_W | Pending interface-interrupt count |
| tag_size_i | input | TAG_W | Remaining size of the current tag |
| cmd_i | input | CMD_W | Active command, zero when none |
| stall_bits_i | input | STALL_W | Stall-status bits |
| dma_en_i | input | 1 | Global DMA enable |
| unit_wait_i | input | 1 | Waiting for the vector unit |
| in_prog_i | input | 1 | Chained transfer in progress |
| fifo_cnt_o | output | CNT_W | Saturated FIFO quadword count |
| int_stat_o | output | 1 | Sticky interrupt status |
| cmd_wait_o | output | 1 | Command status: 1 waiting, 0 idle |
| outcome_o | output | 3 | Last outcome code |
| vif_irq_o | output | 1 | Interface interrupt / pending decrement strobe |
| chain_o | output | 1 | Continue-chain strobe |
| setup_o | output | 1 | Next-tag setup strobe |
| str_clr_o | output | 1 | Channel start clear strobe |
| flags_clr_o | output | 1 | Stall and interrupt-offset flag clear strobe |
| dma_irq_o | output | 1 | DMA-done interrupt strobe |

## Verification
The bench drives two copies of the block from the same inputs: `uut` with `LARGE_FIFO=1` and `uut_small` with `LARGE_FIFO=0`. The 5-bit and 4-bit count widths therefore both get exercised. Quadword counts below, at and above 8 and 16 reach both saturation points in one run. The outcome checks go through every priority level in turn: the stall cases, the wait hold, chaining with DMA masked, mask versus setup, and finish. A held trigger level and input changes made without a trigger show that each trigger produces exactly one evaluation.

// File: rtl/vdc_pkg.sv
package vdc_pkg;
  typedef enum logic [2:0] {
    OUT_NONE   = 3'd0,
    OUT_CHAIN  = 3'd1,
    OUT_SETUP  = 3'd2,
    OUT_STALL  = 3'd3,
    OUT_WAIT   = 3'd4,
    OUT_MASK   = 3'd5,
    OUT_FINISH = 3'd6
  } outcome_e;

  typedef struct packed {
    logic fire;
    logic stall;
  } irq_dec_t;
endpackage

// File: rtl/vdc_fifo_sat.sv
module vdc_fifo_sat #(
  parameter int QWC_W      = 16,
  parameter bit LARGE_FIFO = 1'b1,
  parameter int CNT_W      = 5
) (
  input  logic [QWC_W-1:0] qwc_i,
  output logic [CNT_W-1:0] cnt_o
);
  generate
    if (LARGE_FIFO) begin : g_large
      localparam int DEPTH = 16;
      assign cnt_o = (qwc_i > QWC_W'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(qwc_i);
    end else begin : g_small
      localparam int DEPTH = 8;
      assign cnt_o = (qwc_i > QWC_W'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(qwc_i);
    end
  endgenerate
endmodule

// File: rtl/vdc_irq_gate.sv
module vdc_irq_gate
  import vdc_pkg::*;
#(
  parameter int QWC_W   = 16,
  parameter int PEND_W  = 4,
  parameter int TAG_W   = 16,
  parameter int CMD_W   = 8,
  parameter int STALL_W = 3
) (
  input  logic [PEND_W-1:0]  pend_cnt_i,
  input  logic [TAG_W-1:0]   tag_size_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [STALL_W-1:0] stall_bits_i,
  input  logic [QWC_W-1:0]   qwc_i,
  input  logic               done_i,
  output irq_dec_t           dec_o
);
  logic fire;
  assign fire        = (|pend_cnt_i) && (tag_size_i == '0) && (cmd_i == '0);
  assign dec_o.fire  = fire;
  // stall only when data still outstanding behind the interrupt
  assign dec_o.stall = fire && (|stall_bits_i) && ((|qwc_i) || !done_i);
endmodule

// File: rtl/vdc_outcome.sv
module vdc_outcome
  import vdc_pkg::*;
(
  input  irq_dec_t dec_i,
  input  logic     unit_wait_i,
  input  logic     in_prog_i,
  input  logic     done_i,
  input  logic     dma_en_i,
  output outcome_e outcome_o,
  output logic     stat_upd_o
);
  always_comb begin
    if (dec_i.stall)      outcome_o = OUT_STALL;
    else if (unit_wait_i) outcome_o = OUT_WAIT;
    else if (in_prog_i)   outcome_o = OUT_CHAIN;
    else if (!done_i)     outcome_o = dma_en_i ? OUT_SETUP : OUT_MASK;
    else                  outcome_o = OUT_FINISH;
  end
  assign stat_upd_o = !dec_i.stall && !unit_wait_i;
endmodule

// File: rtl/vdc_top.sv
module vdc_top
  import vdc_pkg::*;
#(
  parameter int QWC_W      = 16,
  parameter int PEND_W     = 4,
  parameter int TAG_W      = 16,
  parameter int CMD_W      = 8,
  parameter int STALL_W    = 3,
  parameter bit LARGE_FIFO = 1'b1,
  localparam int DEPTH     = LARGE_FIFO ? 16 : 8,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eval_i,
  input  logic [QWC_W-1:0]   qwc_i,
  input  logic               done_i,
  input  logic [PEND_W-1:0]  pend_cnt_i,
  input  logic [TAG_W-1:0]   tag_size_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [STALL_W-1:0] stall_bits_i,
  input  logic               dma_en_i,
  input  logic               unit_wait_i,
  input  logic               in_prog_i,
  output logic [CNT_W-1:0]   fifo_cnt_o,
  output logic               int_stat_o,
  output logic               cmd_wait_o,
  output logic [2:0]         outcome_o,
  output logic               vif_irq_o,
  output logic               chain_o,
  output logic               setup_o,
  output logic               str_clr_o,
  output logic               flags_clr_o,
  output logic               dma_irq_o
);
  logic             eval_q, trig;
  logic [CNT_W-1:0] cnt_next;
  irq_dec_t         dec;
  outcome_e         oc_next, oc_q;
  logic             stat_upd;

  assign trig = eval_i && !eval_q;

  vdc_fifo_sat #(.QWC_W(QWC_W), .LARGE_FIFO(LARGE_FIFO), .CNT_W(CNT_W)) u_sat (
    .qwc_i (qwc_i),
    .cnt_o (cnt_next)
  );

  vdc_irq_gate #(
    .QWC_W(QWC_W), .PEND_W(PEND_W), .TAG_W(TAG_W), .CMD_W(CMD_W), .STALL_W(STALL_W)
  ) u_gate (
    .pend_cnt_i   (pend_cnt_i),
    .tag_size_i   (tag_size_i),
    .cmd_i        (cmd_i),
    .stall_bits_i (stall_bits_i),
    .qwc_i        (qwc_i),
    .done_i       (done_i),
    .dec_o        (dec)
  );

  vdc_outcome u_oc (
    .dec_i       (dec),
    .unit_wait_i (unit_wait_i),
    .in_prog_i   (in_prog_i),
    .done_i      (done_i),
    .dma_en_i    (dma_en_i),
    .outcome_o   (oc_next),
    .stat_upd_o  (stat_upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_q      <= 1'b0;
      fifo_cnt_o  <= '0;
      int_stat_o  <= 1'b0;
      cmd_wait_o  <= 1'b0;
      oc_q        <= OUT_NONE;
      vif_irq_o   <= 1'b0;
      chain_o     <= 1'b0;
      setup_o     <= 1'b0;
      str_clr_o   <= 1'b0;
      flags_clr_o <= 1'b0;
      dma_irq_o   <= 1'b0;
    end else begin
      eval_q      <= eval_i;
      vif_irq_o   <= 1'b0;
      chain_o     <= 1'b0;
      setup_o     <= 1'b0;
      str_clr_o   <= 1'b0;
      flags_clr_o <= 1'b0;
      dma_irq_o   <= 1'b0;
      if (trig) begin
        fifo_cnt_o <= cnt_next;
        oc_q       <= oc_next;
        if (dec.fire) begin
          vif_irq_o  <= 1'b1;
          int_stat_o <= 1'b1;
        end
        if (stat_upd) begin
          if (cmd_i == '0)                     cmd_wait_o <= 1'b0;
          else if (done_i && (qwc_i == '0))    cmd_wait_o <= 1'b1;
        end
        chain_o     <= (oc_next == OUT_CHAIN);
        setup_o     <= (oc_next == OUT_SETUP);
        str_clr_o   <= (oc_next == OUT_FINISH);
        flags_clr_o <= (oc_next == OUT_FINISH);
        dma_irq_o   <= (oc_next == OUT_FINISH);
      end
    end
  end

  assign outcome_o = oc_q;

  a_r1_fifo_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_o <= CNT_W'(DEPTH));
  a_r3_int_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_stat_o |=> int_stat_o);
  a_r3_irq_sets_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vif_irq_o |-> int_stat_o);
  a_r4_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vif_irq_o && outcome_o == 3'd3) |-> !(chain_o || setup_o || dma_irq_o));
  a_r7_chain_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o |-> outcome_o == 3'd1);
  a_r9_setup_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_o |-> outcome_o == 3'd2);
  a_r10_finish_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_irq_o |-> (outcome_o == 3'd6 && str_clr_o && flags_clr_o));
  a_r11_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({chain_o, setup_o, dma_irq_o}) > 0 |=> !(chain_o || setup_o || dma_irq_o));
  a_r11_hold_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig |=> $stable(outcome_o));
endmodule

// File: tb/vdc_top_test.sv
`timescale 1ns/1ps
module vdc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval = 1'b0;
  logic [15:0] qwc = '0;
  logic        done = 1'b0;
  logic [3:0]  pend = '0;
  logic [15:0] tag = '0;
  logic [7:0]  cmd = '0;
  logic [2:0]  stall = '0;
  logic        en = 1'b0;
  logic        uwait = 1'b0;
  logic        inprog = 1'b0;

  logic [4:0] fifo_l;
  logic [3:0] fifo_s;
  logic       ints, cwait, virq, chn, setp, sclr, fclr, dirq;
  logic [2:0] oc;
  logic       ints_s, cwait_s, virq_s, chn_s, setp_s, sclr_s, fclr_s, dirq_s;
  logic [2:0] oc_s;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vdc_top #(.LARGE_FIFO(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .qwc_i(qwc), .done_i(done),
    .pend_cnt_i(pend), .tag_size_i(tag), .cmd_i(cmd), .stall_bits_i(stall),
    .dma_en_i(en), .unit_wait_i(uwait), .in_prog_i(inprog),
    .fifo_cnt_o(fifo_l), .int_stat_o(ints), .cmd_wait_o(cwait), .outcome_o(oc),
    .vif_irq_o(virq), .chain_o(chn), .setup_o(setp), .str_clr_o(sclr),
    .flags_clr_o(fclr), .dma_irq_o(dirq));

  vdc_top #(.LARGE_FIFO(1'b0)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .qwc_i(qwc), .done_i(done),
    .pend_cnt_i(pend), .tag_size_i(tag), .cmd_i(cmd), .stall_bits_i(stall),
    .dma_en_i(en), .unit_wait_i(uwait), .in_prog_i(inprog),
    .fifo_cnt_o(fifo_s), .int_stat_o(ints_s), .cmd_wait_o(cwait_s), .outcome_o(oc_s),
    .vif_irq_o(virq_s), .chain_o(chn_s), .setup_o(setp_s), .str_clr_o(sclr_s),
    .flags_clr_o(fclr_s), .dma_irq_o(dirq_s));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic defaults();
    qwc = '0; done = 1'b1; pend = '0; tag = '0; cmd = '0;
    stall = '0; en = 1'b1; uwait = 1'b0; inprog = 1'b0;
  endtask

  // one evaluation; returns at the negedge after the result edge
  task automatic evaluate();
    @(negedge clk); eval = 1'b1;
    @(negedge clk); eval = 1'b0;
  endtask

  task automatic strobes_idle(string req);
    @(negedge clk);
    chk({req, " strobes cleared"}, {virq, chn, setp, sclr, fclr, dirq}, 0);
  endtask

  task automatic t_reset();
    chk("R12 fifo", fifo_l, 0);
    chk("R12 int", ints, 0);
    chk("R12 cmd_wait", cwait, 0);
    chk("R12 outcome", oc, 0);
    chk("R12 strobes", {virq, chn, setp, sclr, fclr, dirq}, 0);
  endtask

  task automatic t_fifo(int q, int el, int es);
    defaults(); qwc = 16'(q); evaluate();
    chk("R1 large fifo", fifo_l, el);
    chk("R2 small fifo", fifo_s, es);
  endtask

  task automatic t_finish();
    defaults(); evaluate();
    chk("R10 outcome", oc, 6);
    chk("R10 str_clr", sclr, 1);
    chk("R10 flags_clr", fclr, 1);
    chk("R10 dma_irq", dirq, 1);
    chk("R10 no vif_irq", virq, 0);
    strobes_idle("R11");
    chk("R11 outcome holds", oc, 6);
  endtask

  task automatic t_setup_mask();
    defaults(); done = 1'b0; qwc = 16'd3; evaluate();
    chk("R9 outcome", oc, 2);
    chk("R9 setup", setp, 1);
    chk("R9 no dma_irq", dirq, 0);
    strobes_idle("R9");
    defaults(); done = 1'b0; en = 1'b0; evaluate();
    chk("R8 outcome", oc, 5);
    chk("R8 no strobes", {setp, chn, dirq, sclr}, 0);
  endtask

  task automatic t_chain();
    defaults(); inprog = 1'b1; done = 1'b0; en = 1'b0; evaluate();
    chk("R7 outcome", oc, 1);
    chk("R7 chain", chn, 1);
    chk("R7 no setup/finish", {setp, dirq}, 0);
    strobes_idle("R7");
  endtask

  task automatic t_irq_blocked();
    defaults(); pend = 4'd1; tag = 16'd3; evaluate();
    chk("R3 tag blocks irq", virq, 0);
    defaults(); pend = 4'd1; cmd = 8'h20; evaluate();
    chk("R3 cmd blocks irq", virq, 0);
    defaults(); stall = 3'b111; qwc = 16'd4; evaluate();
    chk("R3 no pending no irq", virq, 0);
    chk("R3 int still clear", ints, 0);
    chk("R4 no stall without irq", oc, 6);
  endtask

  task automatic t_irq_fire();
    defaults(); pend = 4'd2; evaluate();
    chk("R3 vif_irq", virq, 1);
    chk("R3 int set", ints, 1);
    chk("R3 finishes too", dirq, 1);
    strobes_idle("R3");
    defaults(); evaluate();
    chk("R3 int sticky", ints, 1);
  endtask

  task automatic t_stall();
    defaults(); pend = 4'd1; stall = 3'b010; qwc = 16'd4; evaluate();
    chk("R4 outcome qwc", oc, 3);
    chk("R4 irq fired", virq, 1);
    chk("R4 no strobes", {chn, setp, sclr, fclr, dirq}, 0);
    defaults(); pend = 4'd1; stall = 3'b100; done = 1'b0; inprog = 1'b1; evaluate();
    chk("R4 outcome notdone", oc, 3);
    chk("R4 beats chain", chn, 0);
    defaults(); pend = 4'd1; stall = 3'b001; evaluate();
    chk("R4 drained no stall", oc, 6);
  endtask

  task automatic t_cmd_wait();
    defaults(); cmd = 8'h50; evaluate();
    chk("R6 waiting", cwait, 1);
    defaults(); uwait = 1'b1; evaluate();
    chk("R5 outcome", oc, 4);
    chk("R5 no strobes", {chn, setp, sclr, fclr, dirq}, 0);
    chk("R5 cmd_wait held", cwait, 1);
    defaults(); cmd = 8'h50; done = 1'b0; evaluate();
    chk("R6 hold", cwait, 1);
    defaults(); evaluate();
    chk("R6 idle", cwait, 0);
    defaults(); cmd = 8'h51; qwc = 16'd1; evaluate();
    chk("R6 hold idle", cwait, 0);
    defaults(); pend = 4'd1; stall = 3'b001; qwc = 16'd2; cmd = 8'h0; evaluate();
    defaults(); cmd = 8'h50; evaluate();
    chk("R6 set again", cwait, 1);
    defaults(); pend = 4'd1; stall = 3'b001; qwc = 16'd2; evaluate();
    chk("R4 stall keeps cmd_wait", cwait, 1);
  endtask

  task automatic t_no_eval();
    defaults(); done = 1'b0; evaluate();
    @(negedge clk); defaults(); qwc = 16'd9; pend = 4'd3;
    repeat (3) @(negedge clk);
    chk("R11 outcome held", oc, 2);
    chk("R11 fifo held", fifo_l, 0);
    chk("R11 no strobes", {virq, chn, setp, dirq}, 0);
    defaults();
    @(negedge clk); eval = 1'b1;
    @(negedge clk);
    chk("R11 first edge acts", dirq, 1);
    @(negedge clk);
    chk("R11 level no repeat", dirq, 0);
    eval = 1'b0;
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_irq_blocked();
    t_fifo(5, 5, 5);
    t_fifo(8, 8, 8);
    t_fifo(12, 12, 8);
    t_fifo(16, 16, 8);
    t_fifo(300, 16, 8);
    t_fifo(0, 0, 0);
    t_finish();
    t_setup_mask();
    t_chain();
    t_irq_fire();
    t_stall();
    t_cmd_wait();
    t_no_eval();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule